// File: doc/BRIEF.md
# Keyed-Stop Watchdog Timer

This block is a watchdog counter behind a small synchronous register bus. It comes out of any reset already armed and counting, and when the count runs past all-ones it raises a one-cycle reset request and starts again from a fixed reload value. Software can stop the counter only by posting an ordered pair of key words to one register. A second ordered pair starts it again.

Key writes do not act at once. The counter advances on a slow tick (one tick every `DIV` bus cycles), and each accepted key write stays "posted" for `SYNC_TICKS` ticks before it reaches the key state machine. A posting-status register shows a pending flag while that happens, so software polls it before issuing the next key. A soft-reset command holds the whole block in its default state for `RST_CYC` cycles, re-arms the counter and reports completion through a done flag.

The key state machine has four states. In `KS_LIVE` the counter runs; key `0xAAAA` moves it to `KS_LIVE_KEY1`, where the counter still runs. From `KS_LIVE_KEY1`, key `0x5555` stops the counter (`KS_HALT`), `0xAAAA` stays, and any other key returns to `KS_LIVE`. From `KS_HALT`, key `0xBBBB` moves to `KS_HALT_KEY1`. From there, `0x4444` returns to `KS_LIVE`, `0xBBBB` stays, and any other key returns to `KS_HALT`. The soft-reset controller has two states. `SR_IDLE` moves to `SR_BUSY` on a command. `SR_BUSY` returns to `SR_IDLE` after `RST_CYC` cycles.

Top module: `wdt_keyed_top`

## Requirements
- R1: After hardware reset the counter reads the reload value (default 0xFFC0) and runs. It advances by one every `DIV` bus cycles. STAT (offset 0x14) reads bit1 = running and bit0 = reset done, so it reads 0x3 out of reset.
- R2: A tick that finds the counter at all-ones sets `reset_req` high for exactly one cycle and reloads the counter; COUNT (offset 0x28) reads the reload value in that cycle.
- R3: Key 0xAAAA followed by key 0x5555, each written to KEY (offset 0x48) once the previous write has settled, stops the counter (STAT bit1 = 0).
- R4: An accepted KEY write sets POST (offset 0x34) bit4. The bit stays set for `SYNC_TICKS` counter ticks and then clears, and the key takes effect in that same cycle.
- R5: A KEY write made while POST bit4 is set is dropped. KEY reads back the last accepted word.
- R6: A key other than 0x5555 after 0xAAAA restarts the stop sequence. A repeated 0xAAAA keeps the first half of the sequence.
- R7: While stopped, key 0xBBBB followed by key 0x4444 restarts the counter. A repeated 0xBBBB keeps the first half of this sequence, and any other key restarts it.
- R8: While stopped, COUNT holds its value and `reset_req` never rises.
- R9: Writing CTRL (offset 0x10) with bit1 set starts a soft reset. For `RST_CYC` cycles STAT bit0 reads 0, and KEY and CTRL writes are dropped. POST reads 0, and the counter sits at the reload value. The block then resumes armed with STAT bit0 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and block clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| reset_req | output | 1 | One-cycle system reset request on expiry |

## Verification
A wrong key state shows up at STAT bit1 as soon as the posted key lands, and at COUNT within one tick (`DIV` cycles), because the value either moves when it should hold or holds when it should move. A wrong posting count moves the cycle in which POST bit4 falls, and every later key lands with the same shift. The reference model is compared on every clock, so the first cycle off is reported. A soft-reset sequence that leaves state behind shows at once as a stale POST flag or a COUNT other than the reload value, and later as a `reset_req` pulse that comes at the wrong time.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int KEY_W = 16;

    // register byte offsets
    localparam logic [7:0] OFS_CTRL  = 8'h10;
    localparam logic [7:0] OFS_STAT  = 8'h14;
    localparam logic [7:0] OFS_COUNT = 8'h28;
    localparam logic [7:0] OFS_POST  = 8'h34;
    localparam logic [7:0] OFS_KEY   = 8'h48;

    localparam int POST_BIT = 4;
    localparam int SRST_BIT = 1;

    localparam logic [KEY_W-1:0] KEY_STOP1 = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_STOP2 = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_RUN1  = 16'hBBBB;
    localparam logic [KEY_W-1:0] KEY_RUN2  = 16'h4444;

    typedef enum logic [1:0] {
        KS_LIVE      = 2'd0,
        KS_LIVE_KEY1 = 2'd1,
        KS_HALT      = 2'd2,
        KS_HALT_KEY1 = 2'd3
    } key_state_e;

    typedef enum logic {
        SR_IDLE = 1'b0,
        SR_BUSY = 1'b1
    } srst_state_e;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int               CNT_W  = 16,
    parameter logic [CNT_W-1:0] RELOAD = '0,
    parameter int               DIV    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             run,
    output logic             tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic             req_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    generate
        if (DIV > 1) begin : g_div
            localparam int DIV_W = $clog2(DIV);
            logic [DIV_W-1:0] div_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                          div_q <= '0;
                else if (hold)                       div_q <= '0;
                else if (div_q == DIV_W'(DIV - 1))   div_q <= '0;
                else                                 div_q <= div_q + 1'b1;
            end
            assign tick = !hold && (div_q == DIV_W'(DIV - 1));
        end else begin : g_nodiv
            assign tick = !hold;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RELOAD;
            req_q <= 1'b0;
        end else if (hold) begin
            cnt_q <= RELOAD;
            req_q <= 1'b0;
        end else begin
            req_q <= 1'b0;
            if (tick && run) begin
                if (cnt_q == CNT_MAX) begin
                    cnt_q <= RELOAD;
                    req_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    p_hold_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !hold) |=> $stable(cnt_q));
    p_no_req_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> $past(run));
    p_req_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> (cnt_q == RELOAD));
    p_req_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> !req_q);
endmodule

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm
    import wdt_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int SYNC_TICKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_key,
    output logic              run,
    output logic              pend,
    output logic [DATA_W-1:0] key_q
);
    localparam int PC_W = $clog2(SYNC_TICKS + 1);

    key_state_e       state_q, state_d;
    logic [PC_W-1:0]  pcnt_q;
    logic             accept, apply;

    assign accept = wr_en && !pend && !clear;
    assign apply  = pend && tick && (pcnt_q == PC_W'(1));

    // posting tracker: key reaches the state machine after SYNC_TICKS ticks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend   <= 1'b0;
            pcnt_q <= '0;
            key_q  <= '0;
        end else if (clear) begin
            pend   <= 1'b0;
            pcnt_q <= '0;
        end else if (accept) begin
            pend   <= 1'b1;
            pcnt_q <= PC_W'(SYNC_TICKS);
            key_q  <= wr_key;
        end else if (pend && tick) begin
            pcnt_q <= pcnt_q - 1'b1;
            if (pcnt_q == PC_W'(1)) pend <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state_q <= KS_LIVE;
        else if (clear) state_q <= KS_LIVE;
        else            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (apply) begin
            unique case (state_q)
                KS_LIVE:
                    state_d = (key_q == DATA_W'(KEY_STOP1)) ? KS_LIVE_KEY1 : KS_LIVE;
                KS_LIVE_KEY1:
                    if (key_q == DATA_W'(KEY_STOP2))      state_d = KS_HALT;
                    else if (key_q == DATA_W'(KEY_STOP1)) state_d = KS_LIVE_KEY1;
                    else                                  state_d = KS_LIVE;
                KS_HALT:
                    state_d = (key_q == DATA_W'(KEY_RUN1)) ? KS_HALT_KEY1 : KS_HALT;
                KS_HALT_KEY1:
                    if (key_q == DATA_W'(KEY_RUN2))       state_d = KS_LIVE;
                    else if (key_q == DATA_W'(KEY_RUN1))  state_d = KS_HALT_KEY1;
                    else                                  state_d = KS_HALT;
            endcase
        end
    end

    always_comb begin
        run = (state_q == KS_LIVE) || (state_q == KS_LIVE_KEY1);
    end

    p_pend_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !pend && !clear) |=> pend);
    p_state_only_on_apply_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(state_q) |-> ($past(pend) || $past(clear)));
endmodule

// File: rtl/wdt_soft_rst.sv
module wdt_soft_rst
    import wdt_pkg::*;
#(
    parameter int RST_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic busy,
    output logic done_q
);
    localparam int SC_W = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;

    srst_state_e      state_q, state_d;
    logic [SC_W-1:0]  scnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SR_IDLE: if (req)              state_d = SR_BUSY;
            SR_BUSY: if (scnt_q == '0)     state_d = SR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scnt_q <= '0;
            done_q <= 1'b1;
        end else if (state_q == SR_IDLE && req) begin
            scnt_q <= SC_W'(RST_CYC - 1);
            done_q <= 1'b0;
        end else if (state_q == SR_BUSY) begin
            if (scnt_q == '0) done_q <= 1'b1;
            else              scnt_q <= scnt_q - 1'b1;
        end
    end

    assign busy = (state_q == SR_BUSY);

    p_busy_not_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done_q);
    p_done_on_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_q);
endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
    import wdt_pkg::*;
#(
    parameter int               ADDR_W     = 8,
    parameter int               DATA_W     = 32,
    parameter int               CNT_W      = 16,
    parameter logic [CNT_W-1:0] RELOAD     = 16'hFFC0,
    parameter int               DIV        = 4,
    parameter int               SYNC_TICKS = 4,
    parameter int               RST_CYC    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              reset_req
);
    logic              sr_busy, sr_done, sr_req;
    logic              key_wr, run, pend, tick;
    logic [DATA_W-1:0] key_q;
    logic [CNT_W-1:0]  cnt;

    assign sr_req = bus_we && !sr_busy && (bus_addr == ADDR_W'(OFS_CTRL))
                    && bus_wdata[SRST_BIT];
    assign key_wr = bus_we && !sr_busy && (bus_addr == ADDR_W'(OFS_KEY));

    wdt_soft_rst #(.RST_CYC(RST_CYC)) u_srst (
        .clk(clk), .rst_n(rst_n), .req(sr_req), .busy(sr_busy), .done_q(sr_done)
    );

    wdt_key_fsm #(.DATA_W(DATA_W), .SYNC_TICKS(SYNC_TICKS)) u_keys (
        .clk(clk), .rst_n(rst_n), .clear(sr_busy), .tick(tick),
        .wr_en(key_wr), .wr_key(bus_wdata), .run(run), .pend(pend), .key_q(key_q)
    );

    wdt_counter #(.CNT_W(CNT_W), .RELOAD(RELOAD), .DIV(DIV)) u_cnt (
        .clk(clk), .rst_n(rst_n), .hold(sr_busy), .run(run),
        .tick(tick), .cnt_q(cnt), .req_q(reset_req)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_STAT):  bus_rdata[1:0]        = {run, sr_done};
            ADDR_W'(OFS_COUNT): bus_rdata[CNT_W-1:0]  = cnt;
            ADDR_W'(OFS_POST):  bus_rdata[POST_BIT]   = pend;
            ADDR_W'(OFS_KEY):   bus_rdata             = key_q;
            default:            bus_rdata             = '0;
        endcase
    end
endmodule

// File: tb/sim_wdt_keyed_top.sv
module sim_wdt_keyed_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W  = 16;
    localparam int RELOAD = 'hFFC0;
    localparam int CMAX   = (1 << CNT_W) - 1;
    localparam int DIV    = 4;
    localparam int SYNC   = 4;
    localparam int RSTC   = 6;

    localparam logic [7:0] A_CTRL = 8'h10, A_STAT = 8'h14, A_COUNT = 8'h28,
                           A_POST = 8'h34, A_KEY = 8'h48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        reset_req;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    string cur_req = "R1";

    // behavioural reference model
    int m_div, m_state, m_pend, m_cnt, m_sr_left, m_done;
    int m_key;
    bit m_req;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdt_keyed_top #(.ADDR_W(8), .DATA_W(32), .CNT_W(CNT_W), .RELOAD(16'hFFC0),
                    .DIV(DIV), .SYNC_TICKS(SYNC), .RST_CYC(RSTC)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .reset_req(reset_req)
    );

    task automatic model_reset();
        m_div = 0; m_state = 0; m_pend = 0; m_cnt = RELOAD;
        m_sr_left = 0; m_done = 1; m_key = 0; m_req = 0;
    endtask

    function automatic int next_state(int s, int k);
        case (s)
            0: return (k == 'hAAAA) ? 1 : 0;
            1: return (k == 'h5555) ? 2 : ((k == 'hAAAA) ? 1 : 0);
            2: return (k == 'hBBBB) ? 3 : 2;
            default: return (k == 'h4444) ? 0 : ((k == 'hBBBB) ? 3 : 2);
        endcase
    endfunction

    task automatic model_edge();
        bit busy = (m_sr_left > 0);
        bit tk = !busy && (m_div == DIV - 1);
        bit running = (m_state < 2);
        m_req = 0;
        if (busy) begin
            m_div = 0; m_cnt = RELOAD; m_state = 0; m_pend = 0;
            m_sr_left--;
            if (m_sr_left == 0) m_done = 1;
        end else begin
            if (tk && running) begin
                if (m_cnt == CMAX) begin m_cnt = RELOAD; m_req = 1; end
                else m_cnt++;
            end
            m_div = (m_div + 1) % DIV;
            if (bus_we && bus_addr == A_KEY && m_pend == 0) begin
                m_pend = SYNC; m_key = bus_wdata;
            end else if (m_pend > 0 && tk) begin
                m_pend--;
                if (m_pend == 0) m_state = next_state(m_state, m_key);
            end
            if (bus_we && bus_addr == A_CTRL && bus_wdata[1]) begin
                m_sr_left = RSTC; m_done = 0;
            end
        end
    endtask

    function automatic logic [31:0] model_rdata(logic [7:0] a);
        case (a)
            A_STAT:  return {30'd0, (m_state < 2) ? 1'b1 : 1'b0, m_done[0]};
            A_COUNT: return 32'(m_cnt);
            A_POST:  return (m_pend > 0) ? 32'h10 : 32'h0;
            A_KEY:   return 32'(m_key);
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(logic we, logic [7:0] a, logic [31:0] d);
        bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk({cur_req, " rdata"}, bus_rdata, model_rdata(a));
        chk({cur_req, " reset_req"}, {31'd0, reset_req}, {31'd0, m_req});
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        step(1'b0, a, 32'h0);
        v = bus_rdata;
    endtask

    task automatic wait_post(output int n);
        logic [31:0] v;
        n = 0;
        for (int i = 0; i < 200; i++) begin
            rd(A_POST, v);
            n++;
            if (v[4] == 1'b0) break;
        end
    endtask

    task automatic put_key(logic [31:0] k);
        int n;
        step(1'b1, A_KEY, k);
        wait_post(n);
    endtask

    task automatic run_for_req(string tag);
        logic [31:0] v;
        bit seen = 0;
        for (int i = 0; i < 400; i++) begin
            rd(A_COUNT, v);
            if (reset_req) begin
                seen = 1;
                chk({tag, " reload on expiry"}, v, 32'hFFC0);
                break;
            end
        end
        chk({tag, " reset_req seen"}, {31'd0, seen}, 32'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, c1, c2;
        int n;
        bit any_req;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bus_addr = A_STAT;
        #1;
        // R1: reset state
        chk("R1 STAT after reset", bus_rdata, 32'h3);
        cur_req = "R1";
        rd(A_COUNT, v);
        chk("R1 COUNT near reload", {31'd0, (v == 32'hFFC0) ? 1'b1 : 1'b0}, 32'd1);
        repeat (DIV * 3) rd(A_COUNT, v);
        chk("R1 COUNT advanced by three ticks", v, 32'hFFC3);

        // R2: expiry
        cur_req = "R2";
        run_for_req("R2");

        // R4 + R3: stop sequence with polling
        cur_req = "R4";
        step(1'b1, A_KEY, 32'hAAAA);
        rd(A_POST, v);
        chk("R4 POST bit4 set after key write", v, 32'h10);
        wait_post(n);
        chk("R4 pending window length", {31'd0, (n + 2 >= (SYNC - 1) * DIV && n + 2 <= SYNC * DIV + 1) ? 1'b1 : 1'b0}, 32'd1);
        cur_req = "R3";
        rd(A_STAT, v);
        chk("R3 still running after first key", v, 32'h3);
        put_key(32'h5555);
        rd(A_STAT, v);
        chk("R3 stopped after key pair", v, 32'h1);

        // R8: hold while stopped
        cur_req = "R8";
        rd(A_COUNT, c1);
        any_req = 0;
        for (int i = 0; i < 300; i++) begin
            rd(A_COUNT, c2);
            if (reset_req) any_req = 1;
        end
        chk("R8 COUNT held", c2, c1);
        chk("R8 no reset_req while stopped", {31'd0, any_req}, 32'd0);

        // R5: write while pending dropped
        cur_req = "R5";
        step(1'b1, A_KEY, 32'hBBBB);
        step(1'b1, A_KEY, 32'h1234);
        wait_post(n);
        rd(A_KEY, v);
        chk("R5 KEY keeps accepted word", v, 32'hBBBB);

        // R7: restart
        cur_req = "R7";
        put_key(32'hBBBB);
        rd(A_STAT, v);
        chk("R7 repeated first run key still stopped", v, 32'h1);
        put_key(32'h4444);
        rd(A_STAT, v);
        chk("R7 running after run pair", v, 32'h3);
        rd(A_COUNT, c1);
        repeat (DIV * 2) rd(A_COUNT, c2);
        chk("R7 COUNT moves again", c2 - c1, 32'd2);
        put_key(32'h4444);
        put_key(32'h5555);
        rd(A_STAT, v);
        chk("R7 lone stop word ignored while live", v, 32'h3);

        // R6: broken sequence
        cur_req = "R6";
        put_key(32'hAAAA);
        put_key(32'h1111);
        put_key(32'h5555);
        rd(A_STAT, v);
        chk("R6 broken sequence keeps running", v, 32'h3);
        put_key(32'hAAAA);
        put_key(32'hAAAA);
        put_key(32'h5555);
        rd(A_STAT, v);
        chk("R6 repeated first key then second stops", v, 32'h1);
        put_key(32'hBBBB);
        put_key(32'h7777);
        put_key(32'h4444);
        rd(A_STAT, v);
        chk("R7 broken run sequence stays stopped", v, 32'h1);

        // R9: soft reset re-arms
        cur_req = "R9";
        step(1'b1, A_CTRL, 32'h2);
        rd(A_STAT, v);
        chk("R9 done clear during soft reset", v, 32'h2);
        step(1'b1, A_KEY, 32'hAAAA);
        rd(A_POST, v);
        chk("R9 key write dropped during soft reset", v, 32'h0);
        rd(A_COUNT, v);
        chk("R9 COUNT at reload during soft reset", v, 32'hFFC0);
        for (int i = 0; i < RSTC + 4; i++) begin
            rd(A_STAT, v);
            if (v == 32'h3) break;
        end
        chk("R9 done and armed after soft reset", v, 32'h3);
        run_for_req("R9");

        repeat (5) step(1'b0, A_STAT, 32'h0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule